// File: doc/BRIEF.md
# Output Formatter and Polarisation Splitter

This block takes the final stream of sums produced by an adder tree and converts each sample into an output word through one of eight configurable formats. Each sample is either a full 11-bit sum or a 10-bit sub-group sum. The sample value and a 3-bit format select together pick the mapping. Each of the eight format entries holds a right-shift amount and an 11-bit XOR mask. With these a format can truncate low bits, flip the sign bit to give offset binary, or invert the whole word. The entries are written through a small configuration port.

The formatted stream carries two polarisation channels on alternate accepted samples. The block splits the stream into two parallel channel words, each at half the input sample rate. The first sample of a pair is held and then re-registered together with the second sample, so both channels change in the same cycle and a single strobe marks them as valid. A change of format select is applied only at the start of a pair, so both samples of a pair always use the same format.

Top module: `fmt_pol_split`

## Requirements
- R1: After reset, `outValid`, `chanA` and `chanB` are 0, and every format entry is the identity mapping (shift 0, mask 0).
- R2: A full-sum sample `v` formatted with entry `e` gives `(v >> shift[e]) ^ mask[e]`. `cfgData` bits [10:0] are the mask and bits [14:11] are the shift.
- R3: When `subGroup` is 1, bit 10 of `inData` is ignored: the value used is `{1'b0, inData[9:0]}`, and bit 10 of the formatted output is forced to 0.
- R4: The first accepted sample after reset is an even sample and goes to `chanA`.
- R5: Even samples appear on `chanA` and odd samples on `chanB`. Both words update in the same cycle, and `outValid` pulses for one cycle two clock edges after the odd sample is accepted.
- R6: `outValid` pulses exactly once per pair. An even sample on its own never raises it.
- R7: The format select is sampled with the even sample of a pair. The odd sample uses that same entry, whatever `fmtSel` is when the odd sample arrives.
- R8: Cycles with `inValid` low are ignored. They do not advance the even/odd sequence, and a pair may have any gap between its two samples.
- R9: A write with `cfgWe` high updates entry `cfgAddr` at the clock edge. Samples accepted after that edge use the new entry.
- R10: `chanA` and `chanB` hold their values in every cycle in which `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample present on `inData` this cycle |
| inData | input | 11 | Sum sample (low 10 bits used in sub-group mode) |
| subGroup | input | 1 | Sample is a 10-bit sub-group sum |
| fmtSel | input | 3 | Format select, applied at even samples |
| cfgWe | input | 1 | Write enable for a format entry |
| cfgAddr | input | 3 | Format entry being written |
| cfgData | input | 15 | Entry contents: {shift[3:0], mask[10:0]} |
| outValid | output | 1 | One-cycle strobe: aligned pair present |
| chanA | output | 11 | First-polarisation (even sample) word |
| chanB | output | 11 | Second-polarisation (odd sample) word |

## Verification
The checker tracks the even/odd sequence itself from `inValid` and checks on every cycle the timing relations. A strobe must follow an accepted odd sample by exactly two edges and can never occur in two consecutive cycles. The channel words must stay stable between strobes, and a sub-group odd sample must never produce a set bit 10. The mapped values themselves can only be shown by the bench's scenarios: the identity mapping after reset, shifts and masks, entry rewrites, the select hold across a pair, sub-group masking and gaps inside a pair.

// File: rtl/fmt_pol_pkg.sv
package fmt_pol_pkg;
  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic loadFmt;   // latch a formatted sample
    logic capEven;   // hold staged word as even half of a pair
    logic capOdd;    // staged word is odd half: release aligned pair
  } ctrlStrobes_t;
endpackage

// File: rtl/fmt_pol_ctrl.sv
module fmt_pol_ctrl
  import fmt_pol_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SEL_W-1:0] fmtSel,
  output ctrlStrobes_t     strobes,
  output logic [SEL_W-1:0] selNow
);
  logic             inOdd;     // next accepted sample is odd
  logic [SEL_W-1:0] heldSel;   // select captured with the even sample
  logic             stgValid;
  logic             stgOdd;

  assign selNow = inOdd ? heldSel : fmtSel;

  always_comb begin
    strobes.loadFmt = inValid;
    strobes.capEven = stgValid & ~stgOdd;
    strobes.capOdd  = stgValid & stgOdd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inOdd    <= 1'b0;
      heldSel  <= '0;
      stgValid <= 1'b0;
      stgOdd   <= 1'b0;
    end else begin
      stgValid <= inValid;
      if (inValid) begin
        stgOdd <= inOdd;
        inOdd  <= ~inOdd;
        if (!inOdd) heldSel <= fmtSel;
      end
    end
  end
endmodule

// File: rtl/fmt_pol_datapath.sv
module fmt_pol_datapath
  import fmt_pol_pkg::*;
#(
  parameter int SUM_W = 11,
  parameter int SUB_W = 10,
  parameter int SEL_W = 3,
  parameter int SH_W  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [SEL_W-1:0]      selNow,
  input  logic [SUM_W-1:0]      inData,
  input  logic                  subGroup,
  input  logic                  cfgWe,
  input  logic [SEL_W-1:0]      cfgAddr,
  input  logic [SH_W+SUM_W-1:0] cfgData,
  output logic                  outValid,
  output logic [SUM_W-1:0]      chanA,
  output logic [SUM_W-1:0]      chanB
);
  localparam int NFMT = 1 << SEL_W;
  localparam logic [SUM_W-1:0] SUB_MASK = {{(SUM_W-SUB_W){1'b0}}, {SUB_W{1'b1}}};

  logic [SH_W-1:0]  entryShift [NFMT];
  logic [SUM_W-1:0] entryFlip  [NFMT];

  for (genvar g = 0; g < NFMT; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryShift[g] <= '0;
        entryFlip[g]  <= '0;
      end else if (cfgWe && cfgAddr == SEL_W'(g)) begin
        entryShift[g] <= cfgData[SH_W+SUM_W-1:SUM_W];
        entryFlip[g]  <= cfgData[SUM_W-1:0];
      end
    end
  end

  logic [SUM_W-1:0] srcVal;
  logic [SUM_W-1:0] mapped;

  always_comb begin
    srcVal = subGroup ? (inData & SUB_MASK) : inData;
    mapped = (srcVal >> entryShift[selNow]) ^ entryFlip[selNow];
    if (subGroup) mapped = mapped & SUB_MASK;
  end

  logic [SUM_W-1:0] fmtReg;
  logic [SUM_W-1:0] evenReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtReg   <= '0;
      evenReg  <= '0;
      chanA    <= '0;
      chanB    <= '0;
      outValid <= 1'b0;
    end else begin
      if (strobes.loadFmt) fmtReg  <= mapped;
      if (strobes.capEven) evenReg <= fmtReg;
      outValid <= strobes.capOdd;
      if (strobes.capOdd) begin
        chanA <= evenReg;   // re-register first channel to align with second
        chanB <= fmtReg;
      end
    end
  end
endmodule

// File: rtl/fmt_pol_split.sv
module fmt_pol_split
  import fmt_pol_pkg::*;
#(
  parameter int SUM_W = 11,
  parameter int SUB_W = 10,
  parameter int SEL_W = 3,
  parameter int SH_W  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [SUM_W-1:0]      inData,
  input  logic                  subGroup,
  input  logic [SEL_W-1:0]      fmtSel,
  input  logic                  cfgWe,
  input  logic [SEL_W-1:0]      cfgAddr,
  input  logic [SH_W+SUM_W-1:0] cfgData,
  output logic                  outValid,
  output logic [SUM_W-1:0]      chanA,
  output logic [SUM_W-1:0]      chanB
);
  ctrlStrobes_t     strobes;
  logic [SEL_W-1:0] selNow;

  fmt_pol_ctrl #(.SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fmtSel(fmtSel),
    .strobes(strobes), .selNow(selNow)
  );

  fmt_pol_datapath #(.SUM_W(SUM_W), .SUB_W(SUB_W), .SEL_W(SEL_W), .SH_W(SH_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selNow(selNow),
    .inData(inData), .subGroup(subGroup), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .outValid(outValid), .chanA(chanA), .chanB(chanB)
  );
endmodule

// File: rtl/fmt_pol_split_chk.sv
module fmt_pol_split_chk #(
  parameter int SUM_W = 11,
  parameter int SUB_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             subGroup,
  input logic             outValid,
  input logic [SUM_W-1:0] chanA,
  input logic [SUM_W-1:0] chanB
);
  logic chkOdd;   // independent even/odd tracker
  logic oddAcc;   // odd sample accepted this cycle

  always_ff @(posedge clk) begin
    if (!rstN) chkOdd <= 1'b0;
    else if (inValid) chkOdd <= ~chkOdd;
  end

  assign oddAcc = inValid & chkOdd;

  // R5 / R8: strobe only two edges after an accepted odd sample
  a_r5_strobe_after_odd: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(oddAcc, 2));

  // R6: at most one strobe per pair, never back to back
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R10: channel words hold between strobes
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(chanA) && $stable(chanB)));

  // R3: sub-group odd sample never sets the top bit
  a_r3_sub_msb: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(subGroup, 2)) |-> (chanB[SUM_W-1:SUB_W] == '0));
endmodule

bind fmt_pol_split fmt_pol_split_chk #(.SUM_W(SUM_W), .SUB_W(SUB_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .subGroup(subGroup),
  .outValid(outValid), .chanA(chanA), .chanB(chanB)
);

// File: tb/fmt_pol_split_test.sv
module fmt_pol_split_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [10:0] inData;
  logic        subGroup;
  logic [2:0]  fmtSel;
  logic        cfgWe;
  logic [2:0]  cfgAddr;
  logic [14:0] cfgData;
  logic        outValid;
  logic [10:0] chanA;
  logic [10:0] chanB;

  int checks = 0;
  int failures = 0;

  logic [3:0]  mShift [8];
  logic [10:0] mFlip  [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  fmt_pol_split uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .subGroup(subGroup),
    .fmtSel(fmtSel), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .outValid(outValid), .chanA(chanA), .chanB(chanB)
  );

  function automatic logic [10:0] model(input logic [10:0] v, input logic sub, input int e);
    logic [10:0] s;
    s = sub ? {1'b0, v[9:0]} : v;
    s = (s >> mShift[e]) ^ mFlip[e];
    if (sub) s[10] = 1'b0;
    return s;
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input int e, input logic [3:0] sh, input logic [10:0] fl);
    cfgWe = 1'b1; cfgAddr = 3'(e); cfgData = {sh, fl};
    @(negedge clk);
    cfgWe = 1'b0;
    mShift[e] = sh; mFlip[e] = fl;
  endtask

  task automatic push(input logic [10:0] d, input logic sub, input logic [2:0] sel);
    inValid = 1'b1; inData = d; subGroup = sub; fmtSel = sel;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Push a pair and check the aligned result
  task automatic pairCheck(input string req, input logic [10:0] e, input logic [10:0] o,
                           input logic sub, input logic [2:0] selE, input logic [2:0] selO,
                           input int gap);
    logic [10:0] expA, expB;
    expA = model(e, sub, int'(selE));
    expB = model(o, sub, int'(selE));
    push(e, sub, selE);
    for (int i = 0; i < gap; i++) begin
      check({req, " no strobe mid-pair R6"}, 11'(outValid), 11'd0);
      @(negedge clk);
    end
    push(o, sub, selO);
    check({req, " strobe not early R5"}, 11'(outValid), 11'd0);
    @(negedge clk);
    check({req, " strobe R5"}, 11'(outValid), 11'd1);
    check({req, " chanA"}, chanA, expA);
    check({req, " chanB"}, chanB, expB);
    @(negedge clk);
    check({req, " single pulse R6"}, 11'(outValid), 11'd0);
    check({req, " hold A R10"}, chanA, expA);
    check({req, " hold B R10"}, chanB, expB);
  endtask

  task automatic testReset;
    check("R1 outValid", 11'(outValid), 11'd0);
    check("R1 chanA", chanA, 11'd0);
    check("R1 chanB", chanB, 11'd0);
    pairCheck("R1 R4 identity pair", 11'h5A3, 11'h0F1, 1'b0, 3'd5, 3'd5, 0);
  endtask

  task automatic testFormats;
    writeCfg(1, 4'd2, 11'h000);
    writeCfg(2, 4'd0, 11'h400);
    writeCfg(3, 4'd3, 11'h7FF);
    pairCheck("R2 R9 shift", 11'h7FF, 11'h123, 1'b0, 3'd1, 3'd1, 0);
    pairCheck("R2 sign flip", 11'h3FF, 11'h400, 1'b0, 3'd2, 3'd2, 0);
    pairCheck("R2 shift+invert", 11'h1F8, 11'h008, 1'b0, 3'd3, 3'd3, 0);
  endtask

  task automatic testSelHold;
    pairCheck("R7 select held", 11'h2AA, 11'h155, 1'b0, 3'd1, 3'd2, 0);
    pairCheck("R7 new select at even", 11'h2AA, 11'h155, 1'b0, 3'd2, 3'd1, 0);
  endtask

  task automatic testSubGroup;
    writeCfg(4, 4'd0, 11'h7FF);
    pairCheck("R3 sub invert", 11'h7C3, 11'h400, 1'b1, 3'd4, 3'd4, 0);
    pairCheck("R3 sub identity", 11'h6AB, 11'h4FF, 1'b1, 3'd0, 3'd0, 0);
  endtask

  task automatic testGaps;
    pairCheck("R8 gap 3", 11'h011, 11'h022, 1'b0, 3'd0, 3'd0, 3);
    pairCheck("R8 gap 1", 11'h333, 11'h444, 1'b0, 3'd1, 3'd1, 1);
  endtask

  task automatic testRewrite;
    writeCfg(1, 4'd1, 11'h001);
    pairCheck("R9 rewritten entry", 11'h100, 11'h0FE, 1'b0, 3'd1, 3'd1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mShift[i] = '0; mFlip[i] = '0; end
    rstN = 1'b0; inValid = 1'b0; inData = '0; subGroup = 1'b0; fmtSel = '0;
    cfgWe = 1'b0; cfgAddr = '0; cfgData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFormats();
    testSelHold();
    testSubGroup();
    testGaps();
    testRewrite();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule